// File: doc/BRIEF.md
# Standby and Clock-Mode Controller

This block decides which clocks run in a small microcontroller. Software picks one of two run clocks: the fast main clock or the slow subclock. It can then park the core in a light standby, where only the CPU clock stops, or in a deep standby, where the CPU clock and the peripheral clock both stop. Each standby comes in a fast-clock and a slow-clock flavour. The flavour follows the clock that was running when standby was entered. A level-sensitive wake input brings the core back to that same run clock.

The main oscillator may be switched off in deep standby and during subclock operation. An enable bit allows this, and it only takes effect when the bus-voltage and USB power inputs permit it. If the oscillator was off, the return to the main clock waits a fixed number of stabilisation cycles. The subclock-rate control clock never stops.

The block also merges four reset causes into one stretched synchronous reset. That reset forces fast-clock run: the external pin, a break pulse, an invalid-opcode trap pulse and a watchdog overflow pulse.

Top module: `stby_clk_ctrl`

## Requirements
- R1: After reset the block is in fast-clock run with the select reading 0 (main clock), the oscillator-stop enable reading 1, and all three enables (CPU clock, peripheral clock, main oscillator) at 1.
- R2: `state_o` encodes the state as follows: 0 fast run, 1 slow run, 2 fast light standby, 3 slow light standby, 4 fast deep standby, 5 slow deep standby, 6 oscillator warm-up. The value 7 never appears.
- R3: In light standby (2 or 3) the CPU clock enable is 0 and the peripheral clock enable is 1.
- R4: In deep standby (4 or 5) and in warm-up (6), both the CPU clock enable and the peripheral clock enable are 0.
- R5: A control write with `ctl_hlt_i` or `ctl_stp_i` set picks the standby flavour from the run state it is issued in, and the select bit of that write is ignored. A plain write with `ctl_sub_i`=1 moves to slow run, and one with `ctl_sub_i`=0 moves back towards fast run. `sel_sub_o` tracks the run clock.
- R6: While `wake_i` is high, each standby state leaves on the next clock edge. Fast light standby returns to fast run, both slow standbys return to slow run, and fast deep standby returns to fast run or to warm-up (see R10).
- R7: When a write sets both request bits, deep standby wins over light standby. Control writes are ignored outside the two run states and while `sys_rst_o` is high.
- R8: With the stop enable (`oscs_o`) at 1, the main oscillator enable is 0 in states 1, 3, 4 and 5, subject to R9. With the stop enable at 0 it stays 1 everywhere.
- R9: The main oscillator may only be stopped when `vbus_i` is 0, or when `usb_pd_i` is 1. While `vbus_i`=1 and `usb_pd_i`=0, the main oscillator enable is 1 in every state.
- R10: The block passes through warm-up for exactly STAB_CYC cycles before entering fast run whenever the main oscillator has been off since the last warm-up. This applies to a wake from fast deep standby and to a select write from slow run. If the oscillator stayed on, fast run is entered directly.
- R11: Any of the external pin low (through a 2-flop synchronizer), `brk_i`, `trap_i` or `wdt_i` raises `sys_rst_o`. A pulse cause holds it for RST_HOLD (default 4) cycles after the cycle it is sampled in. While it is high, the state is forced to fast run with the register defaults from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running control clock (subclock rate) |
| rst_ni | input | 1 | External active-low reset pin, asynchronous |
| brk_i | input | 1 | Break-instruction reset pulse |
| trap_i | input | 1 | Invalid-opcode trap reset pulse |
| wdt_i | input | 1 | Watchdog overflow reset pulse |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_hlt_i | input | 1 | Light standby request (self-clearing) |
| ctl_stp_i | input | 1 | Deep standby request (self-clearing) |
| ctl_sub_i | input | 1 | Run clock select, 1 = subclock |
| ctl_oscs_i | input | 1 | Main oscillator stop enable |
| wake_i | input | 1 | Level wake request from interrupt logic |
| vbus_i | input | 1 | Bus voltage present |
| usb_pd_i | input | 1 | USB function in power-down |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| per_clk_en_o | output | 1 | Peripheral clock gate enable |
| main_osc_en_o | output | 1 | Main oscillator enable |
| sys_rst_o | output | 1 | Merged, stretched synchronous reset |
| state_o | output | 3 | Current state code (R2) |
| sel_sub_o | output | 1 | Select readback |
| oscs_o | output | 1 | Stop-enable readback |

## Verification
A wrong state shows up on `state_o` in the cycle after the edge that caused it. Because the three enables decode directly from the state, a misrouted transition also flips a gate enable at once. For example, a fast deep standby that wrongly exits straight to fast run raises the CPU clock enable STAB_CYC cycles too early.

A stale oscillator-lost memory can stay hidden until the next return to the main clock. There it shows up as a missing or unwanted warm-up. The bench therefore restarts the oscillator during standby before it wakes. A wrong reset stretch shows up on `sys_rst_o` within RST_HOLD cycles.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_RUN_HI  = 3'd0,
    ST_RUN_LO  = 3'd1,
    ST_HALT_HI = 3'd2,
    ST_HALT_LO = 3'd3,
    ST_STOP_HI = 3'd4,
    ST_STOP_LO = 3'd5,
    ST_WARM    = 3'd6
  } stby_state_e;

  function automatic logic is_run(stby_state_e s);
    return (s == ST_RUN_HI) || (s == ST_RUN_LO);
  endfunction

  function automatic logic is_halt(stby_state_e s);
    return (s == ST_HALT_HI) || (s == ST_HALT_LO);
  endfunction

  // states where the main oscillator may be parked
  function automatic logic osc_parkable(stby_state_e s);
    return (s == ST_RUN_LO) || (s == ST_HALT_LO) ||
           (s == ST_STOP_HI) || (s == ST_STOP_LO);
  endfunction
endpackage

// File: rtl/stby_rst_merge.sv
module stby_rst_merge #(
  parameter int unsigned NSRC        = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_HOLD    = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  output logic            sys_rst_o
);
  localparam int unsigned CW = $clog2(RST_HOLD + 1);
  localparam logic [CW-1:0] HOLD = CW'(RST_HOLD);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   pin_rst, any_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign pin_rst = ~sync_q[SYNC_STAGES-1];
  assign any_rst = pin_rst | (|src_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= HOLD;
    else if (any_rst)       cnt_q <= HOLD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign sys_rst_o = (cnt_q != '0);
endmodule

// File: rtl/stby_warm_timer.sv
module stby_warm_timer #(
  parameter int unsigned STAB_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(STAB_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(STAB_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= LIM;
    else if (start_i)      cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM);
endmodule

// File: rtl/stby_gate_dec.sv
module stby_gate_dec
  import stby_pkg::*;
(
  input  stby_state_e state_i,
  input  logic        oscs_i,
  input  logic        vbus_i,
  input  logic        usb_pd_i,
  output logic        cpu_clk_en_o,
  output logic        per_clk_en_o,
  output logic        main_osc_en_o
);
  logic stop_permit;

  assign stop_permit   = ~vbus_i | usb_pd_i;
  assign cpu_clk_en_o  = is_run(state_i);
  assign per_clk_en_o  = is_run(state_i) | is_halt(state_i);
  assign main_osc_en_o = ~(oscs_i & stop_permit & osc_parkable(state_i));
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        srst_i,
  input  logic        ctl_we_i,
  input  logic        ctl_hlt_i,
  input  logic        ctl_stp_i,
  input  logic        ctl_sub_i,
  input  logic        ctl_oscs_i,
  input  logic        wake_i,
  input  logic        osc_off_i,
  input  logic        warm_done_i,
  output stby_state_e state_o,
  output logic        sel_sub_o,
  output logic        oscs_o,
  output logic        warm_start_o
);
  stby_state_e state_q, state_d;
  logic        sel_q, sel_d, oscs_q, oscs_d, lost_q, lost_d;
  logic        cold, lo;

  assign cold = lost_q | osc_off_i;
  assign lo   = (state_q == ST_RUN_LO);

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    oscs_d  = oscs_q;
    unique case (state_q)
      ST_RUN_HI, ST_RUN_LO: begin
        if (ctl_we_i) begin
          oscs_d = ctl_oscs_i;
          if (ctl_stp_i)      state_d = lo ? ST_STOP_LO : ST_STOP_HI;
          else if (ctl_hlt_i) state_d = lo ? ST_HALT_LO : ST_HALT_HI;
          else begin
            sel_d = ctl_sub_i;
            if (ctl_sub_i) state_d = ST_RUN_LO;
            else if (lo)   state_d = cold ? ST_WARM : ST_RUN_HI;
          end
        end
      end
      ST_HALT_HI: if (wake_i) state_d = ST_RUN_HI;
      ST_HALT_LO: if (wake_i) state_d = ST_RUN_LO;
      ST_STOP_HI: if (wake_i) state_d = cold ? ST_WARM : ST_RUN_HI;
      ST_STOP_LO: if (wake_i) state_d = ST_RUN_LO;
      ST_WARM:    if (warm_done_i) state_d = ST_RUN_HI;
      default:    state_d = ST_RUN_HI;
    endcase
  end

  // remembers an oscillator outage until a warm-up has completed
  always_comb begin
    lost_d = lost_q;
    if (osc_off_i)                                lost_d = 1'b1;
    else if (state_q == ST_WARM && warm_done_i)   lost_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN_HI;
      sel_q   <= 1'b0;
      oscs_q  <= 1'b1;
      lost_q  <= 1'b0;
    end else if (srst_i) begin
      state_q <= ST_RUN_HI;
      sel_q   <= 1'b0;
      oscs_q  <= 1'b1;
      lost_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      oscs_q  <= oscs_d;
      lost_q  <= lost_d;
    end
  end

  assign warm_start_o = ~srst_i & (state_d == ST_WARM) & (state_q != ST_WARM);
  assign state_o      = state_q;
  assign sel_sub_o    = sel_q;
  assign oscs_o       = oscs_q;
endmodule

// File: rtl/stby_clk_ctrl.sv
module stby_clk_ctrl
  import stby_pkg::*;
#(
  parameter int unsigned STAB_CYC    = 16,
  parameter int unsigned RST_HOLD    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       brk_i,
  input  logic       trap_i,
  input  logic       wdt_i,
  input  logic       ctl_we_i,
  input  logic       ctl_hlt_i,
  input  logic       ctl_stp_i,
  input  logic       ctl_sub_i,
  input  logic       ctl_oscs_i,
  input  logic       wake_i,
  input  logic       vbus_i,
  input  logic       usb_pd_i,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       main_osc_en_o,
  output logic       sys_rst_o,
  output logic [2:0] state_o,
  output logic       sel_sub_o,
  output logic       oscs_o
);
  localparam int unsigned NSRC = 3;

  stby_state_e st;
  logic        warm_start, warm_done, oscs;

  stby_rst_merge #(
    .NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES), .RST_HOLD(RST_HOLD)
  ) u_rst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    ({wdt_i, trap_i, brk_i}),
    .sys_rst_o(sys_rst_o)
  );

  stby_warm_timer #(.STAB_CYC(STAB_CYC)) u_warm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(warm_start),
    .done_o (warm_done)
  );

  stby_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .srst_i      (sys_rst_o),
    .ctl_we_i    (ctl_we_i),
    .ctl_hlt_i   (ctl_hlt_i),
    .ctl_stp_i   (ctl_stp_i),
    .ctl_sub_i   (ctl_sub_i),
    .ctl_oscs_i  (ctl_oscs_i),
    .wake_i      (wake_i),
    .osc_off_i   (~main_osc_en_o),
    .warm_done_i (warm_done),
    .state_o     (st),
    .sel_sub_o   (sel_sub_o),
    .oscs_o      (oscs),
    .warm_start_o(warm_start)
  );

  stby_gate_dec u_dec (
    .state_i      (st),
    .oscs_i       (oscs),
    .vbus_i       (vbus_i),
    .usb_pd_i     (usb_pd_i),
    .cpu_clk_en_o (cpu_clk_en_o),
    .per_clk_en_o (per_clk_en_o),
    .main_osc_en_o(main_osc_en_o)
  );

  assign state_o = st;
  assign oscs_o  = oscs;
endmodule

// File: rtl/stby_clk_ctrl_chk.sv
module stby_clk_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctl_we_i,
  input logic       ctl_stp_i,
  input logic       wake_i,
  input logic       vbus_i,
  input logic       usb_pd_i,
  input logic       cpu_clk_en_o,
  input logic       per_clk_en_o,
  input logic       main_osc_en_o,
  input logic       sys_rst_o,
  input logic [2:0] state_o,
  input logic       oscs_o
);
  p_enc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 3'd7);

  p_halt_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 || state_o == 3'd3) |-> (!cpu_clk_en_o && per_clk_en_o));

  p_stop_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 || state_o == 3'd5) |-> (!cpu_clk_en_o && !per_clk_en_o));

  p_halt_wake_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && wake_i && !sys_rst_o) |=> state_o == 3'd0);

  p_stp_prio_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o <= 3'd1 && ctl_we_i && ctl_stp_i && !sys_rst_o)
      |=> (state_o == 3'd4 || state_o == 3'd5));

  p_quick_osc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oscs_o |-> main_osc_en_o);

  p_osc_permit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vbus_i && !usb_pd_i) |-> main_osc_en_o);

  p_warm_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd6 |-> (!cpu_clk_en_o && !per_clk_en_o && main_osc_en_o));

  p_rst_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |=> sys_rst_o ##1 sys_rst_o ##1 sys_rst_o);

  p_rst_state_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> (state_o == 3'd0 && oscs_o));
endmodule

bind stby_clk_ctrl stby_clk_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctl_we_i     (ctl_we_i),
  .ctl_stp_i    (ctl_stp_i),
  .wake_i       (wake_i),
  .vbus_i       (vbus_i),
  .usb_pd_i     (usb_pd_i),
  .cpu_clk_en_o (cpu_clk_en_o),
  .per_clk_en_o (per_clk_en_o),
  .main_osc_en_o(main_osc_en_o),
  .sys_rst_o    (sys_rst_o),
  .state_o      (state_o),
  .oscs_o       (oscs_o)
);

// File: tb/stby_clk_ctrl_test.sv
module stby_clk_ctrl_test;
  localparam int unsigned STAB = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic brk = 0, trap = 0, wdt = 0;
  logic we = 0, hlt = 0, stp = 0, sub = 0, oscs = 0;
  logic wake = 0, vbus = 0, usb_pd = 0;
  logic cpu_en, per_en, osc_en, sys_rst, sel_sub, oscs_rb;
  logic [2:0] st;

  int checks = 0, errors = 0;

  typedef struct {
    string      tag;
    logic [6:0] v;
  } exp_t;
  exp_t q[$];
  exp_t e;

  always #10 clk = ~clk;

  stby_clk_ctrl #(.STAB_CYC(STAB)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .brk_i(brk), .trap_i(trap), .wdt_i(wdt),
    .ctl_we_i(we), .ctl_hlt_i(hlt), .ctl_stp_i(stp), .ctl_sub_i(sub),
    .ctl_oscs_i(oscs), .wake_i(wake), .vbus_i(vbus), .usb_pd_i(usb_pd),
    .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .main_osc_en_o(osc_en),
    .sys_rst_o(sys_rst), .state_o(st), .sel_sub_o(sel_sub), .oscs_o(oscs_rb)
  );

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if ({sys_rst, st, cpu_en, per_en, osc_en} != e.v[6:0] ||
          0) begin
        errors++;
        $display("FAIL %s actual rst/st/cpu/per/osc=%b expected=%b",
                 e.tag, {sys_rst, st, cpu_en, per_en, osc_en}, e.v);
      end
    end
  end

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  task automatic setup();
    @(negedge clk); #1;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    we = 0; hlt = 0; stp = 0; sub = 0; oscs = 0;
    brk = 0; trap = 0; wdt = 0;
  endtask

  task automatic ex(input string tag, input logic r, input logic [2:0] s,
                    input logic c, input logic p, input logic o);
    exp_t x;
    x.tag = tag;
    x.v   = {r, s, c, p, o};
    q.push_back(x);
  endtask

  // register readback checked directly, between edges
  task automatic ex_reg(input string tag, input logic sb, input logic os);
    #2;
    checks++;
    if ({sel_sub, oscs_rb} != {sb, os}) begin
      errors++;
      $display("FAIL %s actual sel/oscs=%b expected=%b", tag,
               {sel_sub, oscs_rb}, {sb, os});
    end
  endtask

  task automatic wr(input logic h, input logic s, input logic sb, input logic os);
    setup();
    we = 1; hlt = h; stp = s; sub = sb; oscs = os;
    cyc();
  endtask

  task automatic wake_pulse();
    setup(); wake = 1; cyc();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    setup(); rst_ni = 1;
    repeat (4) cyc();
    cyc(); ex("R11 pin reset still held", 1, 3'd0, 1, 1, 1);
    cyc(); ex("R1 reset state", 0, 3'd0, 1, 1, 1);
    ex_reg("R1 reset readback", 0, 1);

    // light standby, fast
    wr(1, 0, 0, 1); ex("R3 fast light standby", 0, 3'd2, 0, 1, 1);
    cyc();          ex("R3 light standby holds", 0, 3'd2, 0, 1, 1);
    wake_pulse();   ex("R6 wake fast light", 0, 3'd0, 1, 1, 1);
    setup(); wake = 0;

    // writes ignored in standby
    wr(1, 0, 0, 1); ex("R7 enter light", 0, 3'd2, 0, 1, 1);
    wr(0, 1, 1, 0); ex("R7 write ignored in standby", 0, 3'd2, 0, 1, 1);
    ex_reg("R7 regs unchanged", 0, 1);
    wake_pulse();   ex("R6 wake after ignored write", 0, 3'd0, 1, 1, 1);
    setup(); wake = 0;

    // quick deep standby
    wr(0, 1, 0, 0); ex("R8 quick deep standby keeps osc", 0, 3'd4, 0, 0, 1);
    wake_pulse();   ex("R10 quick wake no warm-up", 0, 3'd0, 1, 1, 1);
    setup(); wake = 0;

    // deep standby with oscillator stopped
    wr(0, 1, 0, 1); ex("R4 R8 deep standby osc off", 0, 3'd4, 0, 0, 0);
    wake_pulse();   ex("R10 warm-up entered", 0, 3'd6, 0, 0, 1);
    setup(); wake = 0;
    repeat (3) cyc();
    cyc(); ex("R10 warm-up last cycle", 0, 3'd6, 0, 0, 1);
    cyc(); ex("R10 warm-up done", 0, 3'd0, 1, 1, 1);

    // stop blocked by bus voltage
    setup(); vbus = 1;
    wr(0, 1, 0, 1); ex("R9 osc kept by vbus", 0, 3'd4, 0, 0, 1);
    wake_pulse();   ex("R9 blocked stop wakes directly", 0, 3'd0, 1, 1, 1);
    setup(); wake = 0;
    wr(0, 1, 0, 1); ex("R9 deep standby vbus high", 0, 3'd4, 0, 0, 1);
    setup(); usb_pd = 1;
    cyc(); ex("R9 usb power-down permits stop", 0, 3'd4, 0, 0, 0);
    setup(); usb_pd = 0;
    cyc(); ex("R9 osc restarts on usb wake", 0, 3'd4, 0, 0, 1);
    wake_pulse();   ex("R10 outage remembered", 0, 3'd6, 0, 0, 1);
    setup(); wake = 0; vbus = 0;
    repeat (4) cyc();
    cyc(); ex("R10 warm-up after outage done", 0, 3'd0, 1, 1, 1);

    // subclock run and its standbys
    wr(0, 0, 1, 1); ex("R5 R8 slow run osc off", 0, 3'd1, 1, 1, 0);
    ex_reg("R5 select readback", 1, 1);
    wr(1, 0, 1, 1); ex("R5 slow light standby", 0, 3'd3, 0, 1, 0);
    wake_pulse();   ex("R6 wake to slow run", 0, 3'd1, 1, 1, 0);
    setup(); wake = 0;
    wr(1, 1, 0, 1); ex("R7 stop wins, select ignored", 0, 3'd5, 0, 0, 0);
    ex_reg("R5 select kept", 1, 1);
    wake_pulse();   ex("R6 wake slow deep", 0, 3'd1, 1, 1, 0);
    setup(); wake = 0;
    wr(0, 0, 1, 0); ex("R8 quick enable keeps osc in slow run", 0, 3'd1, 1, 1, 1);
    wr(0, 0, 1, 1); ex("R8 slow run osc off again", 0, 3'd1, 1, 1, 0);
    wr(0, 0, 0, 1); ex("R10 switch to main needs warm-up", 0, 3'd6, 0, 0, 1);
    repeat (4) cyc();
    cyc(); ex("R10 switch warm-up done", 0, 3'd0, 1, 1, 1);
    wr(0, 0, 1, 0); ex("R5 slow run osc on", 0, 3'd1, 1, 1, 1);
    wr(0, 0, 0, 0); ex("R10 direct return when osc stayed on", 0, 3'd0, 1, 1, 1);

    // reset sources
    wr(0, 0, 1, 1); ex("R5 slow run before break", 0, 3'd1, 1, 1, 0);
    setup(); brk = 1;
    cyc(); ex("R11 break raises reset", 1, 3'd1, 1, 1, 0);
    cyc(); ex("R11 reset forces fast run", 1, 3'd0, 1, 1, 1);
    ex_reg("R11 regs defaulted", 0, 1);
    cyc(); cyc(); ex("R11 break reset held", 1, 3'd0, 1, 1, 1);
    cyc(); ex("R11 break reset released", 0, 3'd0, 1, 1, 1);
    wr(1, 0, 0, 1); ex("R3 light standby before trap", 0, 3'd2, 0, 1, 1);
    setup(); trap = 1;
    cyc(); ex("R11 trap raises reset", 1, 3'd2, 0, 1, 1);
    cyc(); ex("R11 trap forces fast run", 1, 3'd0, 1, 1, 1);
    repeat (2) cyc();
    cyc(); ex("R11 trap reset released", 0, 3'd0, 1, 1, 1);
    setup(); wdt = 1;
    cyc(); ex("R11 watchdog raises reset", 1, 3'd0, 1, 1, 1);
    repeat (3) cyc();
    cyc(); ex("R11 watchdog reset released", 0, 3'd0, 1, 1, 1);

    wr(0, 0, 1, 1); ex("R5 slow run before pin reset", 0, 3'd1, 1, 1, 0);
    setup(); rst_ni = 0; #1;
    ex("R11 pin reset asynchronous", 1, 3'd0, 1, 1, 1);
    setup(); rst_ni = 1;
    repeat (4) cyc();
    cyc(); ex("R11 pin reset synchronized hold", 1, 3'd0, 1, 1, 1);
    cyc(); ex("R1 state after pin reset", 0, 3'd0, 1, 1, 1);

    setup(); setup();
    report();
  end
endmodule